// File: doc/BRIEF.md
# Packed SIMD Shift-Left Unit

This unit performs a logical left shift on a 32-bit word that holds several packed lanes. All lanes are shifted by one common immediate amount. The word can be read as two 16-bit halfword lanes or as four 8-bit byte lanes. Each lane of the result is the plain truncated shift. The result never saturates, even when a lane loses significant bits.

While it shifts, the unit checks every lane for overflow, and the two formats use different rules. A halfword lane is treated as signed: it overflows when the bits pushed out, together with the new top bit, do not all match the original sign. A byte lane is treated as unsigned: it overflows when any bit pushed out is a one. An overflow in any lane sets a sticky flag, bit 22 of a 32-bit DSP control register. The unit only ever sets this flag. Software clears or reloads the register through a write port.

The result and the flag update are registered one cycle after a valid input. A register write in that same cycle takes the written value, and the new flag is OR-ed on top of it.

Top module: `simd_shl_unit`

## Requirements
- R1: With mode_i = 0 (halfword), the shift amount is shamt_i[3:0]. Each 16-bit lane of result_o is that lane of operand_i shifted left by this amount and truncated to 16 bits.
- R2: With mode_i = 1 (byte), the shift amount is shamt_i[2:0] and shamt_i[3] is ignored. Each 8-bit lane of result_o is that lane shifted left and truncated to 8 bits.
- R3: A shift amount of zero returns operand_i unchanged and never signals overflow.
- R4: A halfword lane overflows when the lane, arithmetic-shifted right by (15 - s), is neither all zeros nor all ones. For example, 0x7FFF8000 shifted by 1 gives 0xFFFE0000 with overflow, and 0x00000001 shifted by 15 gives 0x00008000 with overflow.
- R5: A byte lane overflows when its top s bits are not all zero. For example, 0x00000001 shifted by 7 gives 0x00000080 with no overflow, and 0x87654321 shifted by 3 overflows.
- R6: Overflow in any lane of a valid operation sets ctrl_o[22]. It changes no other bit of ctrl_o.
- R7: ctrl_o[22] is sticky. Once set, it stays set until a register write.
- R8: When ctrl_we_i is high, ctrl_o takes ctrl_wdata_i on the next cycle. If a valid operation in the same cycle overflows, bit 22 is OR-ed in.
- R9: result_o and valid_o appear one cycle after valid_i. When no valid input arrives, result_o holds its value and valid_o is low.
- R10: After reset, result_o, valid_o and ctrl_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 1 | Lane format: 0 = two halfwords, 1 = four bytes |
| operand_i | input | 32 | Packed operand |
| shamt_i | input | 4 | Shift amount (only bits [2:0] are used in byte mode) |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 32 | Control register write data |
| result_o | output | 32 | Registered shifted result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| ctrl_o | output | 32 | DSP control register; bit 22 is the overflow flag |

## Verification
Directed vectors cover the sign-change cases that set the overflow flag:
- a positive halfword that becomes negative;
- a single one bit moved into the halfword sign position.

The byte case that moves a one into bit 7 without overflow shows that byte lanes use unsigned detection. Zero shifts with the sign bits set show that a zero amount never flags overflow. A byte-mode amount with bit 3 set shows that the upper bit is ignored.

Random operands and amounts in both modes, with occasional register writes, compare the result and the full register against a bench model. This exposes lane-boundary leaks, wrong shift directions and write/overflow merging errors. Idle cycles after a flagged operation separate a sticky flag from one that is held only for a cycle.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;
  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_BYTE = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/shl_lane.sv
module shl_lane #(
  parameter int W          = 16,
  parameter bit SIGNED_OVF = 1'b1,
  localparam int SW        = $clog2(W)
) (
  input  logic [W-1:0]  lane_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  lane_o,
  output logic          ovf_o
);
  assign lane_o = lane_i << amt_i;

  generate
    if (SIGNED_OVF) begin : g_signed
      // bits leaving plus new sign must all equal original sign
      logic [SW-1:0]       rs;
      logic signed [W-1:0] disc;
      assign rs    = SW'(W - 1) - amt_i;
      assign disc  = $signed(lane_i) >>> rs;
      assign ovf_o = (amt_i != '0) && !((&disc) || (~|disc));
    end else begin : g_unsigned
      logic [W-1:0] keep_mask;
      assign keep_mask = {W{1'b1}} >> amt_i;
      assign ovf_o     = |(lane_i & ~keep_mask);
    end
  endgenerate
endmodule

// File: rtl/simd_shl_lanes.sv
module simd_shl_lanes
  import simd_shl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int BYTE_W  = 8,
  localparam int SHW    = $clog2(HALF_W),
  localparam int BSW    = $clog2(BYTE_W),
  localparam int N_HALF = DATA_W / HALF_W,
  localparam int N_BYTE = DATA_W / BYTE_W
) (
  input  lane_mode_e        mode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SHW-1:0]    shamt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] half_res, byte_res;
  logic [N_HALF-1:0] half_ovf;
  logic [N_BYTE-1:0] byte_ovf;

  for (genvar i = 0; i < N_HALF; i++) begin : g_half
    shl_lane #(.W(HALF_W), .SIGNED_OVF(1'b1)) u_lane (
      .lane_i (operand_i[i*HALF_W +: HALF_W]),
      .amt_i  (shamt_i),
      .lane_o (half_res[i*HALF_W +: HALF_W]),
      .ovf_o  (half_ovf[i])
    );
  end

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    shl_lane #(.W(BYTE_W), .SIGNED_OVF(1'b0)) u_lane (
      .lane_i (operand_i[i*BYTE_W +: BYTE_W]),
      .amt_i  (shamt_i[BSW-1:0]),
      .lane_o (byte_res[i*BYTE_W +: BYTE_W]),
      .ovf_o  (byte_ovf[i])
    );
  end

  always_comb begin
    if (mode_i == MODE_BYTE) begin
      result_o = byte_res;
      ovf_o    = |byte_ovf;
    end else begin
      result_o = half_res;
      ovf_o    = |half_ovf;
    end
  end
endmodule

// File: rtl/simd_shl_ctrl.sv
module simd_shl_ctrl #(
  parameter int CTRL_W  = 32,
  parameter int OVF_BIT = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              set_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] OVF_MASK = CTRL_W'(1) << OVF_BIT;

  logic [CTRL_W-1:0] ctrl_q, base;

  assign base = we_i ? wdata_i : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= base | (set_i ? OVF_MASK : '0);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/simd_shl_unit.sv
module simd_shl_unit
  import simd_shl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int CTRL_W  = 32,
  parameter int OVF_BIT = 22,
  localparam int SHW    = $clog2(HALF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SHW-1:0]    shamt_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] shl_res;
  logic              shl_ovf;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  simd_shl_lanes #(.DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_lanes (
    .mode_i    (lane_mode_e'(mode_i)),
    .operand_i (operand_i),
    .shamt_i   (shamt_i),
    .result_o  (shl_res),
    .ovf_o     (shl_ovf)
  );

  simd_shl_ctrl #(.CTRL_W(CTRL_W), .OVF_BIT(OVF_BIT)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .set_i   (valid_i && shl_ovf),
    .ctrl_o  (ctrl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= shl_res;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/simd_shl_unit_chk.sv
module simd_shl_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int CTRL_W  = 32,
  parameter int OVF_BIT = 22,
  parameter int SHW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [SHW-1:0]    shamt_i,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] OVF_MASK = CTRL_W'(1) << OVF_BIT;

  logic zero_amt;
  assign zero_amt = mode_i ? (shamt_i[SHW-2:0] == '0) : (shamt_i == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_ZERO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && zero_amt |=> result_o == $past(operand_i)); // R3
  AST_ZERO_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && zero_amt && !ctrl_we_i && !ctrl_o[OVF_BIT] |=> !ctrl_o[OVF_BIT]); // R3
  AST_STICKY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[OVF_BIT] && !ctrl_we_i |=> ctrl_o[OVF_BIT]); // R7
  AST_IDLE_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !ctrl_we_i |=> $stable(ctrl_o)); // R6
  AST_OTHER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> (ctrl_o & ~OVF_MASK) == $past(ctrl_o & ~OVF_MASK)); // R6
  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o & ~OVF_MASK) == ($past(ctrl_wdata_i) & ~OVF_MASK)); // R8
endmodule

bind simd_shl_unit simd_shl_unit_chk #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .OVF_BIT(OVF_BIT), .SHW(SHW)
) u_chk (.*);

// File: tb/simd_shl_unit_test.sv
module simd_shl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [3:0]  shamt_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] result_o;
  logic        valid_o;
  logic [31:0] ctrl_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] ctrl_m = '0;
  logic [31:0] res_m  = '0;

  always #2 clk = ~clk;

  simd_shl_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .operand_i(operand_i), .shamt_i(shamt_i), .ctrl_we_i(ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i), .result_o(result_o), .valid_o(valid_o),
    .ctrl_o(ctrl_o)
  );

  function automatic logic [31:0] exp_res(logic m, logic [31:0] op, logic [3:0] sh);
    logic [31:0] r;
    r = '0;
    if (!m) begin
      for (int i = 0; i < 2; i++) r[i*16 +: 16] = 16'(op[i*16 +: 16] << sh);
    end else begin
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = 8'(op[i*8 +: 8] << sh[2:0]);
    end
    return r;
  endfunction

  function automatic logic exp_ovf(logic m, logic [31:0] op, logic [3:0] sh);
    logic o;
    o = 1'b0;
    if (!m) begin
      if (sh != 0)
        for (int i = 0; i < 2; i++) begin
          logic signed [15:0] d;
          d = $signed(op[i*16 +: 16]) >>> (15 - int'(sh));
          if (d != 16'h0000 && d != 16'hFFFF) o = 1'b1;
        end
    end else begin
      if (sh[2:0] != 0)
        for (int i = 0; i < 4; i++) begin
          int unsigned l;
          l = op[i*8 +: 8];
          if ((l >> (8 - int'(sh[2:0]))) != 0) o = 1'b1;
        end
    end
    return o;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, sample just after the next posedge
  task automatic op(logic v, logic m, logic [31:0] a, logic [3:0] sh,
                    logic we, logic [31:0] wd, string rreq, string creq);
    @(negedge clk);
    valid_i = v; mode_i = m; operand_i = a; shamt_i = sh;
    ctrl_we_i = we; ctrl_wdata_i = wd;
    if (v) res_m = exp_res(m, a, sh);
    ctrl_m = (we ? wd : ctrl_m) | ((v && exp_ovf(m, a, sh)) ? 32'h0040_0000 : 32'h0);
    @(posedge clk);
    #1;
    chk({rreq, " result"}, result_o, res_m);
    chk("R9 valid", {31'b0, valid_o}, {31'b0, v});
    chk({creq, " ctrl"}, ctrl_o, ctrl_m);
    @(negedge clk);
    valid_i = 1'b0; ctrl_we_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #9;
    chk("R10 reset result", result_o, 32'h0);
    chk("R10 reset valid", {31'b0, valid_o}, 32'h0);
    chk("R10 reset ctrl", ctrl_o, 32'h0);
    rst_n = 1'b1;

    op(1, 0, 32'h7FFF_8000, 4'd1,  0, 0, "R1", "R4");
    chk("R4 flag 0x7fff8000<<1", ctrl_o, 32'h0040_0000);
    op(0, 0, 32'h0,         4'd0,  0, 0, "R9", "R7");  // idle: flag must stay
    op(0, 0, 32'h0,         4'd0,  1, 0, "R9", "R8");  // clear by write
    op(1, 0, 32'h0000_0001, 4'd15, 0, 0, "R1", "R4");
    chk("R4 result 1<<15", result_o, 32'h0000_8000);
    op(0, 0, 32'h0, 4'd0, 1, 0, "R9", "R8");
    op(1, 1, 32'h0000_0001, 4'd7,  0, 0, "R2", "R5");
    chk("R5 no flag byte 1<<7", ctrl_o, 32'h0);
    op(1, 1, 32'h8765_4321, 4'd3,  0, 0, "R2", "R5");
    chk("R5 flag 0x87654321<<3", ctrl_o[22], 1'b1);
    op(1, 1, 32'h0000_0000, 4'd1,  0, 0, "R2", "R7"); // no overflow, flag sticks
    op(0, 0, 32'h0, 4'd0, 1, 32'h0000_0005, "R9", "R8");
    op(1, 0, 32'h8000_8000, 4'd0,  0, 0, "R3", "R3");
    op(1, 1, 32'hFFFF_FFFF, 4'd8,  0, 0, "R3", "R3"); // byte amount 0 via bit3 ignored
    op(1, 1, 32'h0101_0101, 4'b1001, 0, 0, "R2", "R5");
    chk("R2 bit3 ignored", result_o, 32'h0202_0202);
    op(1, 0, 32'h4000_0000, 4'd1, 1, 32'h0000_0005, "R1", "R8"); // write + overflow
    chk("R8 merge", ctrl_o, 32'h0040_0005);
    op(1, 0, 32'h0000_1234, 4'd2, 0, 0, "R1", "R6");
    op(0, 1, 32'hDEAD_BEEF, 4'd3, 0, 0, "R9", "R6"); // idle: result holds

    for (int k = 0; k < 400; k++) begin
      logic m, v, we;
      logic [31:0] a, wd;
      logic [3:0] sh;
      m  = 1'($urandom);
      v  = ($urandom % 8) != 0;
      we = ($urandom % 6) == 0;
      a  = $urandom;
      sh = 4'($urandom);
      wd = $urandom;
      op(v, m, a, sh, we, wd, m ? "R2" : "R1", m ? "R5" : "R4");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule